// File: doc/BRIEF.md
# Dual-Edge Up/Down Event Counter

This block is a 16-bit event counter that runs on the system clock. One external pin is the count source. A second external pin sets the direction. Both pins pass through synchronizers into the internal clock domain. Every change of level on the synchronized count-source pin produces one count step, whether the pin rose or fell. The step moves the counter up when the synchronized direction pin is low and down when it is high. The direction pin never produces a step by itself.

Software first writes a start value through a load strobe and then sets the run enable through a separate write strobe. When the counter wraps in either direction, the block issues a one-cycle interrupt request and, in the same cycle, a one-cycle DMA request. Counting stops when software clears the enable, or when the count-source pin stays at one level.

Top module: `updn_event_counter`

## Requirements
- R1: After reset the counter reads 0x0000, the enable is off, and both request outputs are low.
- R2: A load strobe puts `load_val_i` into the counter on the next clock edge, whether or not counting is enabled.
- R3: Count steps change the counter only while the enable is set. `en_wr_i` with `en_val_i` writes the enable, and it gates steps from the following clock edge onward.
- R4: The counter takes exactly one step for each rising edge and each falling edge of `src_pin_i`.
- R5: A step counts up (+1) when the synchronized `dir_pin_i` is 0 and down (-1) when it is 1. The direction level is sampled in the same cycle as the edge it applies to.
- R6: An up step from 0xFFFF leaves 0x0000 and raises `irq_o` and `dma_o` together for exactly one cycle.
- R7: A down step from 0x0000 leaves 0xFFFF and raises `irq_o` and `dma_o` together for exactly one cycle.
- R8: Steps between 0x7FFF and 0x8000, in either direction, and all other non-wrapping steps raise no request.
- R9: When a load strobe and a count step fall in the same cycle, the loaded value wins, and that step raises no request.
- R10: While `src_pin_i` holds one level the counter does not move, even if `dir_pin_i` toggles.
- R11: A level change on `src_pin_i` driven before clock edge 1 shows up in `cnt_o`, together with any request pulse it causes, just after clock edge 3. The path is two synchronizer flops plus the counter register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for the counter value |
| load_val_i | input | 16 | Value to load |
| en_wr_i | input | 1 | Write strobe for the run enable |
| en_val_i | input | 1 | Enable value written by `en_wr_i` |
| src_pin_i | input | 1 | External count-source pin (asynchronous) |
| dir_pin_i | input | 1 | External direction pin: 0 = up, 1 = down (asynchronous) |
| cnt_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle interrupt request on wrap |
| dma_o | output | 1 | One-cycle DMA request on wrap |

## Verification
The bench drives the counter through both wrap points and through the 0x7FFF/0x8000 midpoint. A design that flagged any carry out of bit 14, or missed one of the wraps, would show a wrong request count. It checks the exact three-edge latency and the one-cycle width of the request. An extra flop, or a request held high, would be caught at the cycle sample. A load placed in the very cycle a wrapping step is applied exposes a design that lets the step win or that still pulses the request. Held-source intervals with a toggling direction pin, and bursts of edges on back-to-back cycles, catch designs that count the direction pin, count only one edge polarity, or lose edges that arrive one clock apart.

// File: rtl/updn_evt_pkg.sv
package updn_evt_pkg;

    // Count direction as seen on the synchronized direction pin
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Position of each pin inside the synchronizer vector
    localparam int unsigned PIN_SRC = 0;
    localparam int unsigned PIN_DIR = 1;
    localparam int unsigned PIN_CNT = 2;

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic toggle_o
);

    typedef struct packed {
        logic prev;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d      = h_q;
        h_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    // Any change of level, rising or falling, is one step
    assign toggle_o = lvl_i ^ h_q.prev;

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
    import updn_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             step_i,
    input  logic             dir_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output logic             irq_o,
    output logic             dma_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             irq;
        logic             dma;
    } core_t;

    core_t c_d, c_q;
    logic  wrap;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        c_d.dma = 1'b0;
        wrap    = 1'b0;

        if (en_wr_i) begin
            c_d.en = en_val_i;
        end

        if (load_i) begin
            c_d.cnt = load_val_i;
        end else if (c_q.en && step_i) begin
            if (dir_e'(dir_i) == DIR_DOWN) begin
                c_d.cnt = c_q.cnt - CNT_ONE;
                wrap    = (c_q.cnt == '0);
            end else begin
                c_d.cnt = c_q.cnt + CNT_ONE;
                wrap    = (c_q.cnt == CNT_MAX);
            end
            c_d.irq = wrap;
            c_d.dma = wrap;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;
    assign en_o  = c_q.en;
    assign irq_o = c_q.irq;
    assign dma_o = c_q.dma;

endmodule

// File: rtl/updn_event_counter.sv
module updn_event_counter
    import updn_evt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             src_pin_i,
    input  logic             dir_pin_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             dma_o
);

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_lvl;
    logic               src_step;
    logic               dir_lvl;
    logic               run_en;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_SRC] = src_pin_i;
        pins_raw[PIN_DIR] = dir_pin_i;
    end

    evt_pin_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pins_raw),
        .lvl_o  (pins_lvl)
    );

    evt_edge_det u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (pins_lvl[PIN_SRC]),
        .toggle_o (src_step)
    );

    assign dir_lvl = pins_lvl[PIN_DIR];

    evt_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .en_wr_i    (en_wr_i),
        .en_val_i   (en_val_i),
        .step_i     (src_step),
        .dir_i      (dir_lvl),
        .cnt_o      (cnt_o),
        .en_o       (run_en),
        .irq_o      (irq_o),
        .dma_o      (dma_o)
    );

endmodule

// File: rtl/updn_event_counter_chk.sv
module updn_event_counter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic             en,
    input logic             step,
    input logic             dir,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             dma
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(cnt));

    p_step_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step) |=> !$stable(cnt));

    p_dir_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && !dir) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_dir_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && dir) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    p_up_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && !dir && cnt == MAXV) |=> (irq && dma && cnt == '0));

    p_dn_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && dir && cnt == '0) |=> (irq && dma && cnt == MAXV));

    p_req_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0 || cnt == MAXV));

    p_req_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == dma);

    p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!irq && !dma));

    p_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cnt) && !irq));

endmodule

bind updn_event_counter updn_event_counter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .load     (load_i),
    .load_val (load_val_i),
    .en       (run_en),
    .step     (src_step),
    .dir      (dir_lvl),
    .cnt      (cnt_o),
    .irq      (irq_o),
    .dma      (dma_o)
);

// File: tb/updn_event_counter_bench.sv
module updn_event_counter_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         en_wr = 1'b0;
    logic         en_val = 1'b0;
    logic         src = 1'b0;
    logic         dir = 1'b0;
    logic [W-1:0] cnt;
    logic         irq;
    logic         dma;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int dma_seen = 0;
    int exp_wraps = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updn_event_counter u_updn_event_counter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .en_wr_i    (en_wr),
        .en_val_i   (en_val),
        .src_pin_i  (src),
        .dir_pin_i  (dir),
        .cnt_o      (cnt),
        .irq_o      (irq),
        .dma_o      (dma)
    );

    // Request-pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && irq) irq_seen++;
        if (rst_n && dma) dma_seen++;
    end

    function automatic logic [W:0] step_fn(input logic [W-1:0] v, input logic d);
        logic [W-1:0] n;
        logic         wr;
        if (d) begin
            n  = v - 1'b1;
            wr = (v == '0);
        end else begin
            n  = v + 1'b1;
            wr = (v == '1);
        end
        return {wr, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic do_load(input logic [W-1:0] v);
        @(negedge clk);
        load = 1'b1;
        load_val = v;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        model = v;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en_wr = 1'b1;
        en_val = v;
        @(posedge clk);
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    // One source edge with a given direction, then settle and compare
    task automatic edge_step(input logic d, input logic counting, input string req);
        logic [W:0] r;
        @(negedge clk);
        dir = d;
        src = ~src;
        if (counting) begin
            r = step_fn(model, d);
            model = r[W-1:0];
            if (r[W]) exp_wraps++;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(req, 32'(cnt), 32'(model));
    endtask

    task automatic chk_reqs(input string req);
        chk({req, " irq count"}, 32'(irq_seen), 32'(exp_wraps));
        chk({req, " dma count"}, 32'(dma_seen), 32'(exp_wraps));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", 32'(cnt), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 dma", 32'(dma), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R3: edges while disabled do nothing
        edge_step(1'b0, 1'b0, "R3 disabled");
        edge_step(1'b1, 1'b0, "R3 disabled");

        // R2: load while disabled
        do_load(16'h7FFD);
        chk("R2 load", 32'(cnt), 32'h7FFD);
        set_en(1'b1);

        // R4/R5/R8: up through the midpoint on both edge polarities
        for (int i = 0; i < 4; i++) edge_step(1'b0, 1'b1, "R4 up");
        chk("R8 mid up", 32'(cnt), 32'h8001);
        for (int i = 0; i < 3; i++) edge_step(1'b1, 1'b1, "R5 down");
        chk("R8 mid down", 32'(cnt), 32'h7FFE);
        chk_reqs("R8");

        // R6: up wrap
        do_load(16'hFFFE);
        for (int i = 0; i < 3; i++) edge_step(1'b0, 1'b1, "R6 up wrap");
        chk_reqs("R6");

        // R7: down wrap
        do_load(16'h0001);
        for (int i = 0; i < 3; i++) edge_step(1'b1, 1'b1, "R7 down wrap");
        chk("R7 value", 32'(cnt), 32'hFFFE);
        chk_reqs("R7");

        // R11: exact latency and pulse width
        do_load(16'hFFFF);
        dir = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        src = ~src;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet", 32'(cnt), 32'hFFFF);
        @(posedge clk);
        @(negedge clk);
        chk("R11 edge3 cnt", 32'(cnt), 32'h0000);
        chk("R11 edge3 irq", 32'(irq), 32'h1);
        @(posedge clk);
        @(negedge clk);
        chk("R6 one-cycle irq", 32'(irq), 32'h0);
        model = 16'h0000;
        exp_wraps++;
        chk_reqs("R11");

        // R9: load in the same cycle as a wrapping step
        do_load(16'hFFFF);
        repeat (4) @(posedge clk);
        @(negedge clk);
        dir = 1'b0;
        src = ~src;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        load = 1'b1;
        load_val = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        model = 16'h1234;
        chk("R9 override", 32'(cnt), 32'h1234);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 still", 32'(cnt), 32'h1234);
        chk_reqs("R9");

        // R10: direction pin toggles, source held
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dir = ~dir;
            @(posedge clk);
        end
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R10 held", 32'(cnt), 32'(model));

        // Random phase: bursts of back-to-back edges near wrap points
        for (int k = 0; k < 120; k++) begin
            int n;
            logic d;
            logic [W:0] r;
            if (($urandom % 4) == 0) begin
                logic [W-1:0] v;
                case ($urandom % 3)
                    0: v = W'($urandom % 4);
                    1: v = W'(16'hFFFC + ($urandom % 4));
                    default: v = W'($urandom);
                endcase
                do_load(v);
            end
            n = 1 + int'($urandom % 6);
            d = 1'(($urandom % 2));
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                dir = d;
                src = ~src;
                r = step_fn(model, d);
                model = r[W-1:0];
                if (r[W]) exp_wraps++;
            end
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk("R4 random burst", 32'(cnt), 32'(model));
        end
        chk_reqs("R6 R7 random");

        // R3: clearing enable stops counting
        set_en(1'b0);
        edge_step(1'b0, 1'b0, "R3 cleared");
        edge_step(1'b1, 1'b0, "R3 cleared");

        summary();
    end

endmodule